// File: doc/BRIEF.md
# SPI Byte Master

This block is a full-duplex SPI master that sits between a host and a single serial memory device. Each host request moves one byte. The byte goes out on MOSI, most significant bit first. During the same eight serial clocks, the byte coming back on MISO is collected and handed to the host together with a one-cycle valid strobe.

The host places a byte on `tx_byte`, marks it with `tx_last` if it closes the current command, and pulses `tx_start` while `tx_ready` is high.

Chip select works as follows:
- It goes low when the first byte of a command is accepted.
- It stays low across every following byte of that command.
- It is released only after a byte that carried the last flag has finished.

Because of this, opcodes, address bytes and data bytes of one memory command are framed as a single chip-select window. The serial rate is the system clock divided by the parameter `CLK_DIV`.

Top module: `spi_byte_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: The bus runs in SPI mode 0. `sclk` is 0 whenever chip select is inactive. `mosi` never changes while `sclk` is 1. MISO is sampled at the rising edges of `sclk`.
- R3: Each accepted request sends exactly 8 bits on `mosi`, most significant bit first, one bit per rising edge of `sclk`.
- R4: `rx_byte` holds the 8 MISO bits seen at the 8 rising edges of the same transfer, first bit in the most significant position. `rx_valid` is a single-cycle pulse that rises 16·(CLK_DIV/2) system clocks after the clock edge that accepted the request.
- R5: Every high phase and every in-byte low phase of `sclk` lasts exactly CLK_DIV/2 system clocks (default CLK_DIV = 6). CLK_DIV must be even and at least 2.
- R6: An accepted request drives `cs_n` low on the accepting edge if it was high. The first rising edge of `sclk` follows CLK_DIV/2 system clocks later.
- R7: After a byte without the last flag, `cs_n` stays 0 and `tx_ready` returns to 1 in the same cycle that `rx_valid` is raised.
- R8: After a byte with the last flag, `cs_n` stays 0 for CLK_DIV/2 system clocks after the final falling edge of `sclk`. It then goes to 1 in the same cycle that `tx_ready` returns to 1.
- R9: `tx_ready` is 0 while a byte is in flight. A `tx_start` pulse in that time is ignored: the byte on the wire, the number of bytes sent and the timing are all unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_byte | input | 8 | Byte to transmit, sampled with `tx_start` |
| tx_last | input | 1 | Release chip select after this byte |
| tx_start | input | 1 | Request strobe, accepted only while `tx_ready` is 1 |
| tx_ready | output | 1 | Engine idle and able to accept a request |
| rx_byte | output | 8 | Byte received during the latest transfer |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench acts as a behavioural serial device that shifts a known response stream. It aims at four corner cases:
- Back-to-back bytes inside one chip-select window. A design that released select between bytes would break a multi-byte command.
- The half-period tail before release. Dropping it would cut the hold time after the final edge.
- A start strobe injected mid-byte. A design that accepted it would corrupt the byte on the wire or send an extra one.
- The all-zero and all-one patterns, which expose bit-order and off-by-one shift errors that random data can hide.

// File: rtl/spi_byte_pkg.sv
`timescale 1ns/1ps
package spi_byte_pkg;
    // Sequencer phases of one byte transfer
    typedef enum logic [2:0] {
        SEQ_IDLE,   // waiting for a request (select may still be held)
        SEQ_LEAD,   // select low, clock low before the first rising edge
        SEQ_HIGH,   // clock high phase
        SEQ_LOW,    // clock low phase between bits
        SEQ_TAIL    // select hold after the final falling edge
    } seq_e;
endpackage

// File: rtl/spi_half_timer.sv
`timescale 1ns/1ps
module spi_half_timer #(
    parameter int unsigned HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            tick    = 1'b1;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spi_shift_unit.sv
`timescale 1ns/1ps
module spi_shift_unit #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              tx_adv,
    input  logic              rx_sample,
    input  logic              capture,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rx_out;
        logic              valid;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (load)      s_d.tx = load_byte;
        if (tx_adv)    s_d.tx = {s_q.tx[DATA_W-2:0], 1'b0};
        if (rx_sample) s_d.rx = {s_q.rx[DATA_W-2:0], miso};
        if (capture) begin
            s_d.rx_out = s_q.rx;
            s_d.valid  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mosi     = s_q.tx[DATA_W-1];
    assign rx_byte  = s_q.rx_out;
    assign rx_valid = s_q.valid;
endmodule

// File: rtl/spi_seq_fsm.sv
`timescale 1ns/1ps
module spi_seq_fsm
    import spi_byte_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_in,
    input  logic tick,
    output logic ready,
    output logic run,
    output logic load,
    output logic tx_adv,
    output logic rx_sample,
    output logic capture,
    output logic sclk,
    output logic cs_n
);
    localparam int unsigned BCW = $clog2(DATA_W);
    localparam logic [BCW-1:0] LASTBIT = BCW'(DATA_W - 1);

    typedef struct packed {
        seq_e           st;
        logic [BCW-1:0] bitn;
        logic           last;
        logic           sclk;
        logic           cs_n;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        ready     = (s_q.st == SEQ_IDLE);
        run       = (s_q.st != SEQ_IDLE);
        load      = ready && start;
        rx_sample = tick && (s_q.st == SEQ_LEAD || s_q.st == SEQ_LOW);
        tx_adv    = tick && (s_q.st == SEQ_HIGH) && (s_q.bitn != LASTBIT);
        capture   = tick && (s_q.st == SEQ_HIGH) && (s_q.bitn == LASTBIT);

        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.st   = SEQ_LEAD;
                    s_d.last = last_in;
                    s_d.bitn = '0;
                    s_d.cs_n = 1'b0;
                end
            end
            SEQ_LEAD, SEQ_LOW: begin
                if (tick) begin
                    s_d.st   = SEQ_HIGH;
                    s_d.sclk = 1'b1;
                end
            end
            SEQ_HIGH: begin
                if (tick) begin
                    s_d.sclk = 1'b0;
                    if (s_q.bitn == LASTBIT) begin
                        s_d.st = s_q.last ? SEQ_TAIL : SEQ_IDLE;
                    end else begin
                        s_d.st   = SEQ_LOW;
                        s_d.bitn = s_q.bitn + 1'b1;
                    end
                end
            end
            SEQ_TAIL: begin
                if (tick) begin
                    s_d.st   = SEQ_IDLE;
                    s_d.cs_n = 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= SEQ_IDLE;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk = s_q.sclk;
    assign cs_n = s_q.cs_n;
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master #(
    parameter int unsigned CLK_DIV = 6,
    parameter int unsigned DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_last,
    input  logic              tx_start,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int unsigned HALF_P = CLK_DIV / 2;

    generate
        if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
            $error("CLK_DIV must be even and at least 2");
        end
    endgenerate

    logic tick, run, load, tx_adv, rx_sample, capture;

    spi_half_timer #(.HALF(HALF_P)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_seq_fsm #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_start),
        .last_in   (tx_last),
        .tick      (tick),
        .ready     (tx_ready),
        .run       (run),
        .load      (load),
        .tx_adv    (tx_adv),
        .rx_sample (rx_sample),
        .capture   (capture),
        .sclk      (sclk),
        .cs_n      (cs_n)
    );

    spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (tx_byte),
        .tx_adv    (tx_adv),
        .rx_sample (rx_sample),
        .capture   (capture),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );
endmodule

// File: rtl/spi_byte_master_chk.sv
`timescale 1ns/1ps
module spi_byte_master_chk #(
    parameter int unsigned HALF = 3
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic tx_ready,
    input logic rx_valid
);
    logic [15:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_len <= '0;
        else if (sclk) hi_len <= hi_len + 1'b1;
        else           hi_len <= '0;
    end

    p_clk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == 16'(HALF)));

    p_cs_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk);

    p_release_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> tx_ready);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !tx_ready);
endmodule

bind spi_byte_master spi_byte_master_chk #(.HALF(HALF_P)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid)
);

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;
    localparam int DIV = 6;
    localparam int H   = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_last = 1'b0;
    logic       tx_start = 1'b0;
    logic       tx_ready, rx_valid, sclk, mosi, cs_n;
    logic [7:0] rx_byte;
    logic       miso = 1'b0;

    always #5 clk = ~clk;

    spi_byte_master #(.CLK_DIV(DIV), .DATA_W(8)) i_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_last(tx_last),
        .tx_start(tx_start), .tx_ready(tx_ready), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [7:0] resp(int unsigned k);
        return 8'((k * 73 + 60) ^ (k >> 2));
    endfunction

    // Behavioural serial device: shifts resp(n) out, collects MOSI
    int unsigned sl_bytes = 0;
    int          sl_bit = 0;
    logic [7:0]  sl_sh = '0, sl_last = '0, sl_r;

    always @(negedge cs_n) begin
        sl_bit = 0;
        sl_r   = resp(sl_bytes);
        miso   = sl_r[7];
    end
    always @(posedge sclk) begin
        sl_sh = {sl_sh[6:0], mosi};
        sl_bit++;
        if (sl_bit == 8) begin
            sl_last = sl_sh;
            sl_bytes++;
            sl_bit = 0;
        end
    end
    always @(negedge sclk) begin
        sl_r = resp(sl_bytes);
        miso = sl_r[7 - sl_bit];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit last, input bit poke);
        int cnt, hi, first_hi;
        int unsigned sb0;
        while (!tx_ready) @(negedge clk);
        sb0 = sl_bytes;
        hi = 0; first_hi = 0;
        tx_byte = d; tx_last = last; tx_start = 1'b1;
        @(negedge clk);
        cnt = 1;
        tx_start = 1'b0;
        chk(cs_n == 1'b0, "R6", "cs_n after accept", cs_n, 0);
        chk(tx_ready == 1'b0, "R9", "ready in flight", tx_ready, 0);
        while (!rx_valid && cnt < 40 * H) begin
            if (sclk) begin
                hi++;
                if (first_hi == 0) first_hi = cnt;
            end
            if (poke && cnt == 5 * H) begin
                chk(tx_ready == 1'b0, "R9", "ready mid byte", tx_ready, 0);
                tx_byte = ~d; tx_last = ~last; tx_start = 1'b1;
            end else begin
                tx_start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        tx_start = 1'b0;
        tx_last  = last;
        chk(cnt == 16 * H + 1, "R4", "valid latency", cnt, 16 * H + 1);
        chk(rx_byte == resp(sb0), "R4", "rx_byte", rx_byte, resp(sb0));
        chk(sl_last == d, "R3", "device received", sl_last, d);
        chk(sl_bytes == sb0 + 1, "R9", "bytes on wire", sl_bytes, sb0 + 1);
        chk(hi == 8 * H, "R5", "sclk high cycles", hi, 8 * H);
        chk(first_hi == H + 1, "R6", "first rising edge", first_hi, H + 1);
        if (!last) begin
            chk(cs_n == 1'b0 && tx_ready, "R7", "held select/ready", {cs_n, tx_ready}, 1);
            @(negedge clk);
            chk(rx_valid == 1'b0, "R4", "valid pulse width", rx_valid, 0);
            chk(cs_n == 1'b0, "R7", "select between bytes", cs_n, 0);
        end else begin
            chk(tx_ready == 1'b0, "R8", "ready during tail", tx_ready, 0);
            @(negedge clk);
            chk(rx_valid == 1'b0, "R4", "valid pulse width", rx_valid, 0);
            for (int k = 16 * H + 2; k <= 17 * H + 1; k++) begin
                chk(cs_n == (k == 17 * H + 1), "R8", "select release timing", cs_n, (k == 17 * H + 1));
                if (k != 17 * H + 1) @(negedge clk);
            end
            chk(tx_ready == 1'b1, "R8", "ready after release", tx_ready, 1);
            chk(sclk == 1'b0, "R2", "sclk idle", sclk, 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nb;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "reset bus", {cs_n, sclk}, 2);
        chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R1", "reset host", {tx_ready, rx_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        // single framed byte
        send(8'hA5, 1'b1, 1'b0);
        // multi-byte command in one select window (R7)
        send(8'h90, 1'b0, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        send(8'hFF, 1'b0, 1'b0);
        send(8'h01, 1'b0, 1'b1);
        send(8'h80, 1'b1, 1'b0);
        // ignored start mid byte, last byte (R9)
        send(8'h3C, 1'b1, 1'b1);
        // randomized commands
        for (int c = 0; c < 25; c++) begin
            nb = 1 + int'($urandom % 5);
            for (int b = 0; b < nb; b++)
                send(8'($urandom), b == nb - 1, ($urandom % 4) == 0);
        end
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R2", "final idle", {cs_n, sclk}, 2);
        finish_run();
    end
endmodule